// File: doc/BRIEF.md
# Transmit DMA Channel Status Unit

This unit tracks the state of eight transmit DMA channels that share one status and error view. Each channel has a small configuration register. It selects the run mode and switches credit accounting on or off. A scheduler posts activate commands into a one-entry request buffer for each channel. The unit offers a buffered command downstream over a valid/ready handshake when three things hold: the channel mode allows it, credits are available, and the channel is not paused.

Each channel has a credit counter that mirrors free space in the transmit FIFO. An accepted request spends one credit. A credit return pulse gives one back. The unit reports buffer-empty and no-pending flags for every channel. It keeps sticky error flags for four cases: credit desynchronisation (FIFO full while credits remain), activate overrun, an internal address fault and a host length fault. Software reads and writes everything through a plain register port. A write of 1 to an error bit clears it.

Downstream back-pressure rules: `req_valid[i]` stays high until `req_ready[i]` is seen, unless software rewrites that channel's configuration. A transfer happens in a cycle where both are high. A downstream stage may hold `req_ready` high or low at any time.

Top module: `txdma_chan_status`

## Requirements
- R1: Channel i has a configuration register at byte address i*0x20. It keeps bits 31:30 as the mode (00 off, 01 pause at end of frame, 10 normal, 11 treated as off) and bit 3 as credit enable. All other bits read back as 0, and the reset value is 0.
- R2: An activate pulse loads the channel's one-entry request buffer. `req_valid[i]` is high when the buffer holds a command, the mode allows issue and credit allows issue. A transfer (valid and ready) frees the buffer, and an activate in that same cycle reloads it without error.
- R3: The credit counter resets to CREDIT_MAX. When credit enable is set, each transfer decrements it. Each `credit_ret` pulse increments it. It saturates at 0 and at CREDIT_MAX. With credit enabled and the counter at 0, no request is offered.
- R4: The status register at 0x100 shows buffer-empty in bits 31:24 and no-pending (counter at CREDIT_MAX) in bits 23:16, one bit per channel. Other bits are 0. It reads 0xFFFF0000 after reset. Unmapped addresses read 0.
- R5: Error bit i (7:0) is set when `fifo_full[i]` arrives while credit enable is set and the counter is non-zero.
- R6: Error bit 9+i (16:9) is set when an activate arrives while the buffer is occupied and is not being emptied in that cycle.
- R7: Error bit 31 is set by `addr_err` and bit 30 by `len_err`.
- R8: The error register at 0x108 is sticky. Writing 1 to a bit clears it, a set in the same cycle wins over the clear, and unused bits read 0.
- R9: In pause-at-end mode a channel issues at most one request and then holds until its configuration is written again. In off modes no request is offered, but the buffered command is kept.
- R10: With a channel off, its no-pending flag rises in the cycle after the last outstanding credit is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte address (read and write) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| act | input | NUM_CH | Activate command pulse per channel |
| req_valid | output | NUM_CH | Request offered per channel |
| req_ready | input | NUM_CH | Downstream accepts request per channel |
| fifo_full | input | NUM_CH | Transmit FIFO full indication per channel |
| credit_ret | input | NUM_CH | Credit return pulse per channel |
| addr_err | input | 1 | Internal memory address fault strobe |
| len_err | input | 1 | Host dword count mismatch strobe |

## Verification
A wrong credit count surfaces at the ports in one of three ways. The no-pending status bit may be wrong in the cycle after the event. A request may be offered or withheld wrongly, which shows on `req_valid` at once. A credit error may be flagged or missed on the next FIFO-full pulse. A wrong buffer occupancy shows one cycle after the activate, both in the buffer-empty bit and as a spurious or missing overrun bit. The pause latch is only seen through the lack of a second request, so it is probed by offering `req_ready` again after the first transfer. Saturation is probed by returning more credits than were spent and then counting transfers.

// File: rtl/txdma_cs_pkg.sv
package txdma_cs_pkg;
  typedef enum logic [1:0] {
    MODE_OFF       = 2'b00,
    MODE_PAUSE_EOF = 2'b01,
    MODE_NORMAL    = 2'b10,
    MODE_RSVD      = 2'b11
  } chan_mode_e;

  localparam int unsigned CFG_STRIDE = 32'h20;
  localparam int unsigned STAT_OFS   = 32'h100;
  localparam int unsigned ERR_OFS    = 32'h108;
  localparam int unsigned MAX_CH     = 8;

  localparam int unsigned STAT_EMPTY_LSB = 24;
  localparam int unsigned STAT_IDLE_LSB  = 16;
  localparam int unsigned ERR_CRED_LSB   = 0;
  localparam int unsigned ERR_OVR_LSB    = 9;
  localparam int unsigned ERR_LEN_BIT    = 30;
  localparam int unsigned ERR_ADDR_BIT   = 31;

  localparam int unsigned CFG_CREN_BIT = 3;
endpackage

// File: rtl/txdma_cs_lane.sv
module txdma_cs_lane
  import txdma_cs_pkg::*;
#(
  parameter int unsigned CREDIT_MAX = 4,
  parameter int unsigned CREDIT_W   = $clog2(CREDIT_MAX + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        act,
  input  logic        req_ready,
  input  logic        fifo_full,
  input  logic        credit_ret,
  output logic        req_valid,
  output logic        buf_empty,
  output logic        no_pend,
  output logic        cred_err_set,
  output logic        ovr_set,
  output logic [1:0]  mode,
  output logic        cren,
  output logic [31:0] cfg_rd
);
  localparam logic [CREDIT_W-1:0] CMAX = CREDIT_W'(CREDIT_MAX);

  chan_mode_e          mode_q;
  logic                cren_q;
  logic                occ_q;
  logic                paused_q;
  logic [CREDIT_W-1:0] credit_q;

  logic can_issue;
  logic credit_ok;
  logic fire;
  logic spend;

  always_comb begin
    can_issue = (mode_q == MODE_NORMAL) ||
                ((mode_q == MODE_PAUSE_EOF) && !paused_q);
    credit_ok = !cren_q || (credit_q != '0);
    req_valid = occ_q && can_issue && credit_ok;
    fire      = req_valid && req_ready;
    spend     = fire && cren_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_OFF;
      cren_q   <= 1'b0;
      paused_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q   <= chan_mode_e'(cfg_wdata[31:30]);
      cren_q   <= cfg_wdata[CFG_CREN_BIT];
      paused_q <= 1'b0;
    end else if (fire && (mode_q == MODE_PAUSE_EOF)) begin
      paused_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= 1'b0;
    else        occ_q <= act || (occ_q && !fire);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_q <= CMAX;
    end else if (credit_ret && !spend) begin
      if (credit_q != CMAX) credit_q <= credit_q + 1'b1;
    end else if (spend && !credit_ret) begin
      if (credit_q != '0) credit_q <= credit_q - 1'b1;
    end
  end

  assign buf_empty    = !occ_q;
  assign no_pend      = (credit_q == CMAX);
  assign cred_err_set = fifo_full && cren_q && (credit_q != '0);
  assign ovr_set      = act && occ_q && !fire;
  assign mode         = mode_q;
  assign cren         = cren_q;

  always_comb begin
    cfg_rd               = '0;
    cfg_rd[31:30]        = mode_q;
    cfg_rd[CFG_CREN_BIT] = cren_q;
  end
endmodule

// File: rtl/txdma_cs_errs.sv
module txdma_cs_errs
  import txdma_cs_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cred_set,
  input  logic [NUM_CH-1:0] ovr_set,
  input  logic              addr_err,
  input  logic              len_err,
  input  logic              clr_we,
  input  logic [31:0]       clr_mask,
  output logic [31:0]       err_q
);
  logic [31:0] set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[ERR_ADDR_BIT] = addr_err;
    set_vec[ERR_LEN_BIT]  = len_err;
    for (int i = 0; i < NUM_CH; i++) begin
      set_vec[ERR_CRED_LSB + i] = cred_set[i];
      set_vec[ERR_OVR_LSB + i]  = ovr_set[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~(clr_we ? clr_mask : 32'h0)) | set_vec;
  end
endmodule

// File: rtl/txdma_cs_regmux.sv
module txdma_cs_regmux
  import txdma_cs_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 9
) (
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [32*NUM_CH-1:0] cfg_rd,
  input  logic [31:0]          stat_vec,
  input  logic [31:0]          err_vec,
  output logic [31:0]          reg_rdata
);
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(STAT_OFS)) reg_rdata = stat_vec;
    if (reg_addr == ADDR_W'(ERR_OFS))  reg_rdata = err_vec;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ADDR_W'(i * CFG_STRIDE)) reg_rdata = cfg_rd[32*i +: 32];
    end
  end
endmodule

// File: rtl/txdma_chan_status.sv
module txdma_chan_status
  import txdma_cs_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned CREDIT_MAX = 4,
  parameter int unsigned ADDR_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] act,
  output logic [NUM_CH-1:0] req_valid,
  input  logic [NUM_CH-1:0] req_ready,
  input  logic [NUM_CH-1:0] fifo_full,
  input  logic [NUM_CH-1:0] credit_ret,
  input  logic              addr_err,
  input  logic              len_err
);
  localparam int unsigned CREDIT_W = $clog2(CREDIT_MAX + 1);

  initial begin
    if (NUM_CH > MAX_CH) $error("NUM_CH exceeds the status field width");
  end

  logic [NUM_CH-1:0]   buf_empty;
  logic [NUM_CH-1:0]   no_pend;
  logic [NUM_CH-1:0]   cred_set;
  logic [NUM_CH-1:0]   ovr_set;
  logic [NUM_CH-1:0]   cren_vec;
  logic [2*NUM_CH-1:0] mode_vec;
  logic [32*NUM_CH-1:0] cfg_rd;
  logic [31:0]         stat_vec;
  logic [31:0]         err_vec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic cfg_we;
    assign cfg_we = reg_wr && (reg_addr == ADDR_W'(g * CFG_STRIDE));

    txdma_cs_lane #(
      .CREDIT_MAX (CREDIT_MAX),
      .CREDIT_W   (CREDIT_W)
    ) u_lane (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wdata    (reg_wdata),
      .act          (act[g]),
      .req_ready    (req_ready[g]),
      .fifo_full    (fifo_full[g]),
      .credit_ret   (credit_ret[g]),
      .req_valid    (req_valid[g]),
      .buf_empty    (buf_empty[g]),
      .no_pend      (no_pend[g]),
      .cred_err_set (cred_set[g]),
      .ovr_set      (ovr_set[g]),
      .mode         (mode_vec[2*g +: 2]),
      .cren         (cren_vec[g]),
      .cfg_rd       (cfg_rd[32*g +: 32])
    );
  end

  always_comb begin
    stat_vec = '0;
    stat_vec[STAT_EMPTY_LSB +: NUM_CH] = buf_empty;
    stat_vec[STAT_IDLE_LSB  +: NUM_CH] = no_pend;
  end

  txdma_cs_errs #(.NUM_CH(NUM_CH)) u_errs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cred_set (cred_set),
    .ovr_set  (ovr_set),
    .addr_err (addr_err),
    .len_err  (len_err),
    .clr_we   (reg_wr && (reg_addr == ADDR_W'(ERR_OFS))),
    .clr_mask (reg_wdata),
    .err_q    (err_vec)
  );

  txdma_cs_regmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_mux (
    .reg_addr  (reg_addr),
    .cfg_rd    (cfg_rd),
    .stat_vec  (stat_vec),
    .err_vec   (err_vec),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/txdma_cs_checker.sv
module txdma_cs_checker
  import txdma_cs_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NUM_CH-1:0] act,
  input logic [NUM_CH-1:0] req_valid,
  input logic [NUM_CH-1:0] req_ready,
  input logic [NUM_CH-1:0] fifo_full,
  input logic              addr_err,
  input logic              len_err,
  input logic [31:0]       stat_vec,
  input logic [31:0]       err_vec,
  input logic [NUM_CH-1:0] cren_vec,
  input logic [2*NUM_CH-1:0] mode_vec
);
  logic              err_wr;
  logic [NUM_CH-1:0] empty_v;
  logic [NUM_CH-1:0] idle_v;
  logic [NUM_CH-1:0] ovr_ev;
  logic [NUM_CH-1:0] cr_ev;

  assign err_wr  = reg_wr && (reg_addr == ADDR_W'(ERR_OFS));
  assign empty_v = stat_vec[STAT_EMPTY_LSB +: NUM_CH];
  assign idle_v  = stat_vec[STAT_IDLE_LSB +: NUM_CH];
  assign ovr_ev  = act & ~empty_v & ~(req_valid & req_ready);
  assign cr_ev   = fifo_full & cren_vec & idle_v;

  AST_REQ_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & empty_v) == '0); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (($past(req_valid) & ~$past(req_ready) & ~req_valid) == '0)); // R2

  AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ev != '0) |=> ((err_vec[ERR_OVR_LSB +: NUM_CH] & $past(ovr_ev)) == $past(ovr_ev))); // R6

  AST_CREDIT_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_ev != '0) |=> ((err_vec[ERR_CRED_LSB +: NUM_CH] & $past(cr_ev)) == $past(cr_ev))); // R5

  AST_ADDR_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> err_vec[ERR_ADDR_BIT]); // R7

  AST_LEN_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> err_vec[ERR_LEN_BIT]); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !err_wr |=> ((err_vec & $past(err_vec)) == $past(err_vec))); // R8

  for (genvar g = 0; g < NUM_CH; g++) begin : g_off
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[2*g +: 2] == 2'b00) |-> !req_valid[g]); // R9
  end
endmodule

bind txdma_chan_status txdma_cs_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .act       (act),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .fifo_full (fifo_full),
  .addr_err  (addr_err),
  .len_err   (len_err),
  .stat_vec  (stat_vec),
  .err_vec   (err_vec),
  .cren_vec  (cren_vec),
  .mode_vec  (mode_vec)
);

// File: tb/txdma_chan_status_tb.sv
module txdma_chan_status_tb;
  localparam int NV = 41;

  typedef struct packed {
    logic        wr;
    logic [8:0]  addr;
    logic [31:0] wdata;
    logic [7:0]  act;
    logic [7:0]  rdy;
    logic [7:0]  full;
    logic [7:0]  ret;
    logic [1:0]  ext;
    logic [8:0]  caddr;
    logic [31:0] cval;
    logic [7:0]  crv;
    logic [7:0]  req;
  } vec_t;

  // wr addr wdata act rdy full ret ext | check addr, value, req_valid, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b1, 9'h000, 32'h80000008, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h000, 32'h80000008, 8'h00, 8'd1},  // R1
    '{1'b1, 9'h020, 32'hFFFFFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h020, 32'hC0000008, 8'h00, 8'd1},  // R1 masking
    '{1'b0, 9'h000, 32'h0,        8'h01, 8'h00, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFEFF0000, 8'h01, 8'd2},  // R2 load
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h01, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFFFE0000, 8'h00, 8'd3},  // R3 spend
    '{1'b0, 9'h000, 32'h0,        8'h01, 8'h00, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFEFE0000, 8'h01, 8'd2},  // R2
    '{1'b0, 9'h000, 32'h0,        8'h01, 8'h00, 8'h00, 8'h00, 2'b00, 9'h108, 32'h00000200, 8'h01, 8'd6},  // R6 overrun
    '{1'b0, 9'h000, 32'h0,        8'h01, 8'h01, 8'h00, 8'h00, 2'b00, 9'h108, 32'h00000200, 8'h01, 8'd6},  // R6 reload on transfer
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h01, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFFFE0000, 8'h00, 8'd3},  // R3
    '{1'b0, 9'h000, 32'h0,        8'h01, 8'h01, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFEFE0000, 8'h01, 8'd2},  // R2
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h01, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFFFE0000, 8'h00, 8'd3},  // R3 credit 0
    '{1'b0, 9'h000, 32'h0,        8'h01, 8'h00, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFEFE0000, 8'h00, 8'd3},  // R3 stall
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h01, 8'h00, 2'b00, 9'h108, 32'h00000200, 8'h00, 8'd5},  // R5 no error at 0
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h00, 8'h01, 2'b00, 9'h100, 32'hFEFE0000, 8'h01, 8'd3},  // R3 return
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h01, 8'h00, 2'b00, 9'h108, 32'h00000201, 8'h01, 8'd5},  // R5 error
    '{1'b1, 9'h108, 32'h00000200, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h108, 32'h00000001, 8'h01, 8'd8},  // R8 partial clear
    '{1'b1, 9'h108, 32'h00000001, 8'h00, 8'h00, 8'h01, 8'h00, 2'b00, 9'h108, 32'h00000001, 8'h01, 8'd8},  // R8 set wins
    '{1'b1, 9'h108, 32'hFFFFFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h108, 32'h00000000, 8'h01, 8'd8},  // R8
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h00, 8'h00, 2'b11, 9'h108, 32'hC0000000, 8'h01, 8'd7},  // R7
    '{1'b1, 9'h108, 32'h40000000, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h108, 32'h80000000, 8'h01, 8'd8},  // R8
    '{1'b1, 9'h108, 32'h80000000, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h108, 32'h00000000, 8'h01, 8'd8},  // R8
    '{1'b1, 9'h000, 32'h00000000, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFEFE0000, 8'h00, 8'd9},  // R9 off keeps command
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h00, 8'h01, 2'b00, 9'h100, 32'hFEFE0000, 8'h00, 8'd10}, // R10
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h00, 8'h01, 2'b00, 9'h100, 32'hFEFE0000, 8'h00, 8'd10}, // R10
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h00, 8'h01, 2'b00, 9'h100, 32'hFEFF0000, 8'h00, 8'd10}, // R10 drained
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h00, 8'h01, 2'b00, 9'h100, 32'hFEFF0000, 8'h00, 8'd3},  // R3 saturate high
    '{1'b1, 9'h000, 32'h80000008, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h000, 32'h80000008, 8'h01, 8'd2},  // R2
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h01, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFFFE0000, 8'h00, 8'd3},  // R3 after saturation
    '{1'b1, 9'h040, 32'h40000008, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h040, 32'h40000008, 8'h00, 8'd1},  // R1
    '{1'b0, 9'h000, 32'h0,        8'h04, 8'h00, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFBFE0000, 8'h04, 8'd9},  // R9
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h04, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFFFA0000, 8'h00, 8'd9},  // R9 one issue
    '{1'b0, 9'h000, 32'h0,        8'h04, 8'h04, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFBFA0000, 8'h00, 8'd9},  // R9 paused
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h04, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFBFA0000, 8'h00, 8'd9},  // R9 paused
    '{1'b1, 9'h040, 32'h40000008, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFBFA0000, 8'h04, 8'd9},  // R9 re-armed
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h04, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFFFA0000, 8'h00, 8'd9},  // R9
    '{1'b1, 9'h060, 32'h80000000, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 9'h060, 32'h80000000, 8'h00, 8'd1},  // R1
    '{1'b0, 9'h000, 32'h0,        8'h08, 8'h08, 8'h00, 8'h00, 2'b00, 9'h100, 32'hF7FA0000, 8'h08, 8'd2},  // R2
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h08, 8'h00, 8'h00, 2'b00, 9'h100, 32'hFFFA0000, 8'h00, 8'd3},  // R3 credit disabled
    '{1'b0, 9'h000, 32'h0,        8'h00, 8'h00, 8'h08, 8'h00, 2'b00, 9'h108, 32'h00000000, 8'h00, 8'd5},  // R5 no error without credit
    '{1'b0, 9'h000, 32'h0,        8'h30, 8'h00, 8'h00, 8'h00, 2'b00, 9'h100, 32'hCFFA0000, 8'h00, 8'd4},  // R4 two channels
    '{1'b0, 9'h000, 32'h0,        8'h02, 8'h00, 8'h00, 8'h00, 2'b00, 9'h100, 32'hCDFA0000, 8'h00, 8'd9},  // R9 mode 11
    '{1'b0, 9'h000, 32'h0,        8'h10, 8'h00, 8'h00, 8'h00, 2'b00, 9'h108, 32'h00002000, 8'h00, 8'd6}   // R6 ch4
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  act, req_valid, req_ready, fifo_full, credit_ret;
  logic        addr_err, len_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  txdma_chan_status u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .act        (act),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .fifo_full  (fifo_full),
    .credit_ret (credit_ret),
    .addr_err   (addr_err),
    .len_err    (len_err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr = 1'b0; reg_wdata = '0; act = '0; req_ready = '0;
    fifo_full = '0; credit_ret = '0; addr_err = 1'b0; len_err = 1'b0;
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_reset();
    idle_inputs();
    reg_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
  endtask

  task automatic reset_checks(input string when);
    logic [31:0] d;
    peek(9'h100, d); check({"R4 status after reset ", when}, d, 32'hFFFF0000);
    peek(9'h108, d); check({"R8 errors after reset ", when}, d, 32'h0);
    peek(9'h000, d); check({"R1 config after reset ", when}, d, 32'h0);
    check({"R2 no request after reset ", when}, {24'h0, req_valid}, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    run_reset();
    reset_checks("start");
    peek(9'h104, d); check("R4 unmapped read", d, 32'h0);

    for (int k = 0; k < NV; k++) begin
      reg_wr = VEC[k].wr; reg_addr = VEC[k].addr; reg_wdata = VEC[k].wdata;
      act = VEC[k].act; req_ready = VEC[k].rdy; fifo_full = VEC[k].full;
      credit_ret = VEC[k].ret; {addr_err, len_err} = VEC[k].ext;
      @(posedge clk);
      #1;
      idle_inputs();
      peek(VEC[k].caddr, d);
      check($sformatf("R%0d step %0d reg %h", VEC[k].req, k, VEC[k].caddr), d, VEC[k].cval);
      check($sformatf("R%0d step %0d req_valid", VEC[k].req, k), {24'h0, req_valid}, {24'h0, VEC[k].crv});
    end

    // mid-run reset returns everything to its initial state (R4, R8, R1)
    run_reset();
    reset_checks("mid-run");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule